// File: doc/BRIEF.md
# Context-Driven Reconfigurable Cell Datapath

This block is one processing cell of a coarse-grain reconfigurable array. A 32-bit context word, captured into a context register whenever the load strobe is high, chooses what the cell does. The cell repeats that operation on every clock edge until a new word replaces it. A sequencer that streams one word per cycle therefore reconfigures the cell every cycle, and each word takes effect one edge after it is loaded. The datapath holds a 16-bit ALU with status flags, a variable-distance shifter that works on 32-bit register pairs, a signed 16x16 multiplier, a multiply-accumulate unit with a 32-bit accumulator, a dual 8-bit complex multiplier with an optional conjugate, and a bank of sixteen 16-bit registers. The flags can gate any operation, so conditional execution costs no branch.

The control is a two-state machine. EMPTY is the state after reset, when no context has been loaded yet and nothing executes. ACTIVE is the state in which the held context runs on every edge. The transitions are named as follows. HOLD_EMPTY keeps the cell in EMPTY while the strobe is low. LOAD_FIRST moves the cell from EMPTY to ACTIVE on the first strobe. RUN keeps the cell in ACTIVE for good; only reset leaves it.

Context word fields: opcode [31:28], destination register [27:24], source A [23:20], source B [19:16], conditional enable [15], flag select [14:13], immediate or shift distance [12:0]. Opcodes: 0 NOP, 1 LDA, 2 LDB, 3 ADD, 4 SUB, 5 AND, 6 OR, 7 XOR, 8 SHL, 9 SHR, 10 MUL, 11 MACC, 12 MAC, 13 CMUL, 14 ACCR, 15 ADDI. Register pair k consists of register 2k (low half) and register 2k+1 (high half). A pair operation names the pair through bits [3:1] of a register field.

Top module: `rcell_core`

## Requirements
- R1: After reset, result, flags and acc are all zero, the cell is EMPTY, and these outputs stay unchanged until the first edge after a context has been loaded.
- R2: A word present with ctx_load high is captured at that edge, and the context held before that edge is the one that executes there. From the next edge on, the captured word executes on every edge until it is replaced, and it reads the buses anew each time.
- R3: LDA writes opa_in and LDB writes opb_in to the destination register. result shows the value written.
- R4: ADD, SUB and ADDI (ADDI adds the 13-bit immediate, sign-extended) write a 16-bit result. Flags are bit0 Z (result zero), bit1 N (result bit 15), bit2 C (carry out for an add; A >= B unsigned for SUB), bit3 V (signed overflow).
- R5: AND, OR and XOR write the bitwise result and set Z and N from it. C and V are cleared.
- R6: SHL (logical) and SHR (arithmetic) shift the 32-bit pair named by source A by immediate bits [4:0] and write the pair named by the destination. result shows the low half.
- R7: MUL writes the signed 32-bit product of registers A and B into the destination pair.
- R8: MACC loads the accumulator with the signed product A*B in place of its old value. result shows the low half of the new accumulator.
- R9: MAC adds the signed product to the accumulator, modulo 2^32. result shows the low half. The accumulator changes on MACC and MAC only.
- R10: CMUL treats each operand as real in [15:8] and imaginary in [7:0], both signed 8-bit. It computes re = ar*br - ai*bi and im = ar*bi + ai*br, each kept modulo 2^16, and writes re to the low half and im to the high half of the destination pair. Immediate bit 0 set negates bi first (conjugate of B).
- R11: ACCR copies the accumulator into the destination pair.
- R12: When bit 15 is set and the flag chosen by bits [14:13] (0 Z, 1 N, 2 C, 3 V) is clear, the operation has no effect: no register write, and flags, acc and result keep their values.
- R13: Only ADD, SUB, AND, OR, XOR and ADDI change the flags. Every other opcode leaves them as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctx_load | input | 1 | Capture ctx_word into the context register |
| ctx_word | input | 32 | Context word to capture |
| opa_in | input | 16 | Operand bus A, read by LDA |
| opb_in | input | 16 | Operand bus B, read by LDB |
| result | output | 16 | Value produced by the last executed operation |
| flags | output | 4 | {V, C, N, Z} |
| acc | output | 32 | Accumulator |

## Verification
The sums and differences are swept across the sign and carry boundaries (0, 1, 0x7FFF, 0x8000, 0xFFFF). A design with the carry sense of SUB inverted, or with overflow taken from the wrong operand, gives wrong C or V. Shifts run over all 32 distances in both directions, which exposes a logical shift used in place of an arithmetic one, or halves of a pair that are swapped. The complex products use the byte extremes -128 and 127 with and without conjugation, so a sign slip in the imaginary term or a mixed-up real and imaginary byte shows up. Conditional execution is tried with every flag select against live flag states: a cell that wrote the register, the flags or the accumulator despite a clear flag, or that tested the wrong flag, gives a different readback. The accumulator is driven past 2^32, and a first product that is added instead of loaded leaves a stale offset.

// File: rtl/rcell_pkg.sv
package rcell_pkg;

    localparam int IMM_W = 13;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDA  = 4'd1,
        OP_LDB  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_MUL  = 4'd10,
        OP_MACC = 4'd11,
        OP_MAC  = 4'd12,
        OP_CMUL = 4'd13,
        OP_ACCR = 4'd14,
        OP_ADDI = 4'd15
    } op_e;

    typedef enum logic {
        CTX_EMPTY  = 1'b0,
        CTX_ACTIVE = 1'b1
    } cell_state_e;

    // bit0 zero, bit1 negative, bit2 carry, bit3 overflow
    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;

    typedef struct packed {
        op_e              op;
        logic [3:0]       dst;
        logic [3:0]       src_a;
        logic [3:0]       src_b;
        logic             cond;
        logic [1:0]       fsel;
        logic [IMM_W-1:0] imm;
    } ctx_t;

endpackage

// File: rtl/rcell_regbank.sv
module rcell_regbank #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG),
    localparam int PW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we16,
    input  logic          we32,
    input  logic [AW-1:0] waddr,
    input  logic [PW-1:0] wdata,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    output logic [PW-1:0] rpair_a
);

    logic [DW-1:0] rf [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(g);
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we16 && waddr == IDX) begin
                q <= wdata[DW-1:0];
            end else if (we32 && waddr[AW-1:1] == IDX[AW-1:1]) begin
                q <= IDX[0] ? wdata[PW-1:DW] : wdata[DW-1:0];
            end
        end
        assign rf[g] = q;
    end

    assign rdata_a = rf[ra];
    assign rdata_b = rf[rb];
    assign rpair_a = {rf[{ra[AW-1:1], 1'b1}], rf[{ra[AW-1:1], 1'b0}]};

endmodule

// File: rtl/rcell_alu.sv
module rcell_alu
    import rcell_pkg::*;
#(
    parameter int DW  = 16,
    localparam int PW = 2 * DW,
    localparam int SW = $clog2(PW)
) (
    input  op_e              op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [IMM_W-1:0] imm,
    input  logic [PW-1:0]    pair,
    output logic [PW-1:0]    res,
    output flags_t           flg
);

    logic [DW-1:0] imm_x;
    logic [DW-1:0] bx;
    logic [DW:0]   sum;
    logic          word_op;

    assign imm_x = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
    assign bx    = (op == OP_ADDI) ? imm_x : b;

    always_comb begin
        sum     = '0;
        res     = '0;
        flg     = '0;
        word_op = 1'b1;
        case (op)
            OP_ADD, OP_ADDI: begin
                sum   = {1'b0, a} + {1'b0, bx};
                flg.c = sum[DW];
                flg.v = (a[DW-1] == bx[DW-1]) && (sum[DW-1] != a[DW-1]);
            end
            OP_SUB: begin
                sum   = {1'b0, a} + {1'b0, ~b} + (DW+1)'(1);
                flg.c = sum[DW];
                flg.v = (a[DW-1] != b[DW-1]) && (sum[DW-1] != a[DW-1]);
            end
            OP_AND: sum = {1'b0, a & b};
            OP_OR:  sum = {1'b0, a | b};
            OP_XOR: sum = {1'b0, a ^ b};
            OP_SHL: begin
                word_op = 1'b0;
                res     = pair << imm[SW-1:0];
            end
            OP_SHR: begin
                word_op = 1'b0;
                res     = PW'($signed(pair) >>> imm[SW-1:0]);
            end
            default: word_op = 1'b0;
        endcase
        if (word_op) begin
            res = {{DW{1'b0}}, sum[DW-1:0]};
        end
        flg.z = (sum[DW-1:0] == '0);
        flg.n = sum[DW-1];
    end

endmodule

// File: rtl/rcell_mul.sv
module rcell_mul #(
    parameter int DW  = 16,
    localparam int PW = 2 * DW,
    localparam int HW = DW / 2,
    localparam int XW = DW + 2
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          conj,
    output logic [PW-1:0] prod,
    output logic [PW-1:0] cplx
);

    logic signed [PW-1:0] a_w, b_w;
    logic signed [HW-1:0] ar, ai, br, bi;
    logic signed [XW-1:0] ar_w, ai_w, br_w, bi_w, bi_c;
    logic signed [XW-1:0] re_w, im_w;

    assign a_w  = PW'($signed(a));
    assign b_w  = PW'($signed(b));
    assign prod = a_w * b_w;

    assign ar   = a[DW-1:HW];
    assign ai   = a[HW-1:0];
    assign br   = b[DW-1:HW];
    assign bi   = b[HW-1:0];
    assign ar_w = XW'(ar);
    assign ai_w = XW'(ai);
    assign br_w = XW'(br);
    assign bi_w = XW'(bi);
    assign bi_c = conj ? -bi_w : bi_w;

    assign re_w = ar_w * br_w - ai_w * bi_c;
    assign im_w = ar_w * bi_c + ai_w * br_w;
    assign cplx = {im_w[DW-1:0], re_w[DW-1:0]};

endmodule

// File: rtl/rcell_core.sv
module rcell_core
    import rcell_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int PW      = 2 * DATA_W,
    localparam int RAW     = $clog2(NUM_REGS),
    localparam int CTX_W   = $bits(ctx_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctx_load,
    input  logic [CTX_W-1:0]  ctx_word,
    input  logic [DATA_W-1:0] opa_in,
    input  logic [DATA_W-1:0] opb_in,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags,
    output logic [PW-1:0]     acc
);

    cell_state_e state_q, state_d;
    ctx_t        ctx_q;
    flags_t      flags_q, flags_d, alu_flags;
    logic [PW-1:0]     acc_q, acc_d;
    logic [DATA_W-1:0] res_q, res_d;
    logic              cell_active, go;
    logic              we16, we32;
    logic [PW-1:0]     wdata;
    logic [DATA_W-1:0] reg_a, reg_b;
    logic [PW-1:0]     pair_a, alu_res, mul_prod, mul_cplx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTX_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: HOLD_EMPTY, LOAD_FIRST, RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTX_EMPTY:  if (ctx_load) state_d = CTX_ACTIVE;
            CTX_ACTIVE: state_d = CTX_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctx_q <= '0;
        else if (ctx_load) ctx_q <= ctx_t'(ctx_word);
    end

    assign cell_active = (state_q == CTX_ACTIVE);
    assign go = cell_active && (!ctx_q.cond || flags_q[ctx_q.fsel]);

    rcell_regbank #(.DW(DATA_W), .NREG(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we16    (we16),
        .we32    (we32),
        .waddr   (ctx_q.dst[RAW-1:0]),
        .wdata   (wdata),
        .ra      (ctx_q.src_a[RAW-1:0]),
        .rb      (ctx_q.src_b[RAW-1:0]),
        .rdata_a (reg_a),
        .rdata_b (reg_b),
        .rpair_a (pair_a)
    );

    rcell_alu #(.DW(DATA_W)) u_alu (
        .op   (ctx_q.op),
        .a    (reg_a),
        .b    (reg_b),
        .imm  (ctx_q.imm),
        .pair (pair_a),
        .res  (alu_res),
        .flg  (alu_flags)
    );

    rcell_mul #(.DW(DATA_W)) u_mul (
        .a    (reg_a),
        .b    (reg_b),
        .conj (ctx_q.imm[0]),
        .prod (mul_prod),
        .cplx (mul_cplx)
    );

    // Outputs of the executing context
    always_comb begin
        we16    = 1'b0;
        we32    = 1'b0;
        wdata   = '0;
        flags_d = flags_q;
        acc_d   = acc_q;
        res_d   = res_q;
        if (go) begin
            unique case (ctx_q.op)
                OP_NOP: ;
                OP_LDA: begin
                    we16  = 1'b1;
                    wdata = {{DATA_W{1'b0}}, opa_in};
                end
                OP_LDB: begin
                    we16  = 1'b1;
                    wdata = {{DATA_W{1'b0}}, opb_in};
                end
                OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_ADDI: begin
                    we16    = 1'b1;
                    wdata   = alu_res;
                    flags_d = alu_flags;
                end
                OP_SHL, OP_SHR: begin
                    we32  = 1'b1;
                    wdata = alu_res;
                end
                OP_MUL: begin
                    we32  = 1'b1;
                    wdata = mul_prod;
                end
                OP_CMUL: begin
                    we32  = 1'b1;
                    wdata = mul_cplx;
                end
                OP_ACCR: begin
                    we32  = 1'b1;
                    wdata = acc_q;
                end
                OP_MACC: acc_d = mul_prod;
                OP_MAC:  acc_d = acc_q + mul_prod;
            endcase
            if (we16 || we32) res_d = wdata[DATA_W-1:0];
            if (ctx_q.op == OP_MACC || ctx_q.op == OP_MAC) res_d = acc_d[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            acc_q   <= '0;
            res_q   <= '0;
        end else begin
            flags_q <= flags_d;
            acc_q   <= acc_d;
            res_q   <= res_d;
        end
    end

    assign result = res_q;
    assign flags  = flags_q;
    assign acc    = acc_q;

endmodule

// File: rtl/rcell_core_chk.sv
module rcell_core_chk
    import rcell_pkg::*;
#(
    parameter int DW  = 16,
    localparam int PW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic [31:0]   ctx_bits,
    input logic [DW-1:0] opa_in,
    input logic [DW-1:0] result,
    input logic [3:0]    flags,
    input logic [PW-1:0] acc,
    input logic [PW-1:0] prod
);

    logic [3:0] op;
    logic       fires;
    logic       flag_op;

    assign op      = ctx_bits[31:28];
    assign fires   = active && (!ctx_bits[15] || flags[ctx_bits[14:13]]);
    assign flag_op = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
                     (op == OP_OR)  || (op == OP_XOR) || (op == OP_ADDI);

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(result) && $stable(flags) && $stable(acc)); // R1

    AST_LOAD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        fires && op == OP_LDA |=> result == $past(opa_in)); // R3

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fires && op == OP_MACC |=> acc == $past(prod)); // R8

    AST_ACC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        fires && op == OP_MAC |=> acc == $past(acc) + $past(prod)); // R9

    AST_ACC_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        !(fires && (op == OP_MAC || op == OP_MACC)) |=> $stable(acc)); // R9

    AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        active && !fires |=> $stable(result) && $stable(flags) && $stable(acc)); // R12

    AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(fires && flag_op) |=> $stable(flags)); // R13

endmodule

bind rcell_core rcell_core_chk #(.DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (cell_active),
    .ctx_bits (ctx_q),
    .opa_in   (opa_in),
    .result   (result),
    .flags    (flags),
    .acc      (acc),
    .prod     (mul_prod)
);

// File: tb/rcell_core_tb.sv
module rcell_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_load = 1'b0;
    logic [31:0] ctx_word = '0;
    logic [15:0] opa_in = '0;
    logic [15:0] opb_in = '0;
    logic [15:0] result;
    logic [3:0]  flags;
    logic [31:0] acc;

    int checks = 0;
    int errors = 0;

    logic [15:0] m [16];
    logic [3:0]  mf;
    logic [31:0] macc;
    logic [15:0] mres;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcell_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctx_load (ctx_load),
        .ctx_word (ctx_word),
        .opa_in   (opa_in),
        .opb_in   (opb_in),
        .result   (result),
        .flags    (flags),
        .acc      (acc)
    );

    function automatic logic [15:0] vsel(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'hFF80;
            default: return 16'h00FF;
        endcase
    endfunction

    function automatic logic [7:0] bsel(input int k);
        case (k)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h7F;
            3: return 8'h80;
            4: return 8'hFF;
            5: return 8'h35;
            6: return 8'hC3;
            default: return 8'h40;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] d, input logic [3:0] sa,
                                       input logic [3:0] sb, input logic cnd, input logic [1:0] fs,
                                       input logic [12:0] imm);
        return {op, d, sa, sb, cnd, fs, imm};
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] w);
        @(negedge clk);
        ctx_load = 1'b1;
        ctx_word = w;
        @(negedge clk);
        ctx_word = '0;
        @(negedge clk);
        ctx_load = 1'b0;
    endtask

    task automatic step(input string rq, input logic [3:0] op, input logic [3:0] d, input logic [3:0] sa,
                        input logic [3:0] sb, input logic cnd, input logic [1:0] fs, input logic [12:0] imm);
        logic [15:0] a, b, bx, r16;
        logic [16:0] s;
        logic [31:0] p, w32;
        logic exe, wr16, wr32, fl, nc, nv;
        int ia, ib, ar, ai, br, bi, re, im;
        string frq;
        a = m[sa]; b = m[sb];
        exe = !cnd || mf[fs];
        wr16 = 0; wr32 = 0; fl = 0; nc = 0; nv = 0; r16 = '0; w32 = '0; s = '0; bx = '0;
        p  = {m[{sa[3:1], 1'b1}], m[{sa[3:1], 1'b0}]};
        ia = $signed(a); ib = $signed(b);
        if (exe) begin
            case (op)
                4'd1: begin r16 = opa_in; wr16 = 1; end
                4'd2: begin r16 = opb_in; wr16 = 1; end
                4'd3, 4'd15: begin
                    bx  = (op == 4'd15) ? {{3{imm[12]}}, imm} : b;
                    s   = {1'b0, a} + {1'b0, bx};
                    r16 = s[15:0]; wr16 = 1; fl = 1;
                    nc  = s[16];
                    nv  = (a[15] == bx[15]) && (r16[15] != a[15]);
                end
                4'd4: begin
                    s   = {1'b0, a} - {1'b0, b};
                    r16 = s[15:0]; wr16 = 1; fl = 1;
                    nc  = (a >= b);
                    nv  = (a[15] != b[15]) && (r16[15] != a[15]);
                end
                4'd5: begin r16 = a & b; wr16 = 1; fl = 1; end
                4'd6: begin r16 = a | b; wr16 = 1; fl = 1; end
                4'd7: begin r16 = a ^ b; wr16 = 1; fl = 1; end
                4'd8: begin w32 = p << imm[4:0]; wr32 = 1; end
                4'd9: begin w32 = $signed(p) >>> imm[4:0]; wr32 = 1; end
                4'd10: begin w32 = ia * ib; wr32 = 1; end
                4'd11: begin macc = ia * ib; mres = macc[15:0]; end
                4'd12: begin macc = macc + ia * ib; mres = macc[15:0]; end
                4'd13: begin
                    ar = $signed(a[15:8]); ai = $signed(a[7:0]);
                    br = $signed(b[15:8]); bi = $signed(b[7:0]);
                    if (imm[0]) bi = -bi;
                    re = ar * br - ai * bi;
                    im = ar * bi + ai * br;
                    w32 = {16'(im), 16'(re)}; wr32 = 1;
                end
                4'd14: begin w32 = macc; wr32 = 1; end
                default: ;
            endcase
            if (wr16) begin m[d] = r16; mres = r16; end
            if (wr32) begin
                m[{d[3:1], 1'b0}] = w32[15:0];
                m[{d[3:1], 1'b1}] = w32[31:16];
                mres = w32[15:0];
            end
            if (fl) mf = {nv, nc, r16[15], (r16 == 16'h0)};
        end
        run(mk(op, d, sa, sb, cnd, fs, imm));
        frq = !exe ? "R12" : (fl ? rq : "R13");
        chk(exe ? rq : "R12", "result", {16'h0, result}, {16'h0, mres});
        chk(frq, "flags", {28'h0, flags}, {28'h0, mf});
        chk(exe ? (op == 4'd11 ? "R8" : "R9") : "R12", "acc", acc, macc);
    endtask

    // Read a register back through OR r,r into register 15
    task automatic peek(input string rq, input logic [3:0] r);
        step(rq, 4'd6, 4'd15, r, r, 1'b0, 2'd0, 13'h0);
    endtask

    task automatic lda(input logic [3:0] r, input logic [15:0] v);
        opa_in = v;
        step("R3", 4'd1, r, 4'd0, 4'd0, 1'b0, 2'd0, 13'h0);
    endtask

    task automatic ldb(input logic [3:0] r, input logic [15:0] v);
        opb_in = v;
        step("R3", 4'd2, r, 4'd0, 4'd0, 1'b0, 2'd0, 13'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = '0;
        mf = '0; macc = '0; mres = '0;

        // R1: reset state and quiet EMPTY state
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        opa_in = 16'hBEEF;
        repeat (4) @(negedge clk);
        chk("R1", "result", {16'h0, result}, 32'h0);
        chk("R1", "flags", {28'h0, flags}, 32'h0);
        chk("R1", "acc", acc, 32'h0);

        // R2: load edge runs the old context, new one repeats afterwards
        opa_in   = 16'h1111;
        ctx_word = mk(4'd1, 4'd0, 4'd0, 4'd0, 1'b0, 2'd0, 13'h0);
        ctx_load = 1'b1;
        @(negedge clk);
        ctx_load = 1'b0;
        chk("R2", "result after load edge", {16'h0, result}, 32'h0);
        @(negedge clk);
        chk("R2", "result first run", {16'h0, result}, 32'h1111);
        opa_in = 16'h2222;
        @(negedge clk);
        chk("R2", "result repeat", {16'h0, result}, 32'h2222);
        m[0] = 16'h2222; mres = 16'h2222;
        peek("R2", 4'd0);

        // R4 R5 R12: arithmetic, logic and conditional sweeps
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                lda(4'd1, vsel(i));
                ldb(4'd2, vsel(j));
                step("R4", 4'd3, 4'd3, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
                step("R4", 4'd4, 4'd4, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
                step("R4", 4'd15, 4'd5, 4'd1, 4'd0, 1'b0, 2'd0, vsel(j)[12:0]);
                step("R5", 4'd5, 4'd6, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
                step("R5", 4'd6, 4'd7, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
                step("R5", 4'd7, 4'd8, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
                step("R4", 4'd4, 4'd3, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
                step("R12", 4'd3, 4'd9, 4'd1, 4'd2, 1'b1, 2'((i + j) % 4), 13'h0);
                peek("R12", 4'd9);
                step("R12", 4'd12, 4'd0, 4'd1, 4'd2, 1'b1, 2'((i + 2 * j) % 4), 13'h0);
            end
        end

        // R6: shifts over every distance
        lda(4'd4, 16'h8001);
        lda(4'd5, 16'hF0F0);
        for (int k = 0; k < 32; k++) begin
            step("R6", 4'd8, 4'd6, 4'd4, 4'd0, 1'b0, 2'd0, 13'(k));
            peek("R6", 4'd7);
            step("R6", 4'd9, 4'd10, 4'd5, 4'd0, 1'b0, 2'd0, 13'(k));
            peek("R6", 4'd11);
        end

        // R7 R10: products
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                lda(4'd1, vsel(i));
                ldb(4'd2, vsel(j));
                step("R7", 4'd10, 4'd12, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
                peek("R7", 4'd13);
                lda(4'd3, {bsel(i), bsel(j)});
                ldb(4'd4, {bsel(j), bsel(7 - i)});
                step("R10", 4'd13, 4'd6, 4'd3, 4'd4, 1'b0, 2'd0, 13'h0);
                peek("R10", 4'd7);
                step("R10", 4'd13, 4'd8, 4'd3, 4'd4, 1'b0, 2'd0, 13'h1);
                peek("R10", 4'd9);
            end
        end

        // R8 R9 R11: accumulation, restart and wrap
        for (int r = 0; r < 3; r++) begin
            lda(4'd1, vsel(r + 2));
            ldb(4'd2, vsel(r + 3));
            step("R8", 4'd11, 4'd0, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
            for (int k = 0; k < 8; k++) begin
                lda(4'd1, vsel(k));
                step("R9", 4'd12, 4'd0, 4'd1, 4'd2, 1'b0, 2'd0, 13'h0);
            end
            step("R11", 4'd14, 4'd10, 4'd0, 4'd0, 1'b0, 2'd0, 13'h0);
            peek("R11", 4'd11);
        end
        lda(4'd1, 16'h8000);
        step("R8", 4'd11, 4'd0, 4'd1, 4'd1, 1'b0, 2'd0, 13'h0);
        for (int k = 0; k < 5; k++) step("R9", 4'd12, 4'd0, 4'd1, 4'd1, 1'b0, 2'd0, 13'h0);
        step("R11", 4'd14, 4'd12, 4'd0, 4'd0, 1'b0, 2'd0, 13'h0);
        peek("R11", 4'd13);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule